// File: doc/BRIEF.md
# Per-Thread Instruction Push Router

This block takes 32-bit instruction stores from the cores of a compute tile and places each word into one of three instruction queues, one for each coprocessor thread. The target queue depends on the store address and on the core that issued the store. The control core addresses any thread through that thread's own window. A compute core always reaches its own thread through the first window; its store to any other window can never complete. The second data-movement core may not push at all. Its stores are dropped and reported on a one-cycle error output.

Each queue holds 32 words. Back-pressure is a single combinational ready signal on the store port. When the target queue is full, ready stays low until a slot frees. A store that can never complete holds ready low until reset and sets a sticky per-core hang flag. The consumers drain the queues through valid/ready pop handshakes. Each queue reports its occupancy.

Top module: `instr_push_hub`

## Requirements
- R1: The thread windows begin at 0xFFE40000, 0xFFE50000 and 0xFFE60000 for threads 0, 1 and 2, and each window is 0x10000 bytes. Every word offset inside a window selects the same thread.
- R2: Core ID 0 is the control core. Its store to window n is accepted and pushes the data word into thread n's queue.
- R3: Core IDs 2, 3 and 4 are compute cores 0, 1 and 2. A store from compute core k to window 0 pushes into thread k's queue.
- R4: A store from a compute core to window 1 or 2 sees st_ready low. From the next cycle, hang_status bit <core ID> is set. From then until reset, st_ready stays low for every store from every core.
- R5: A store to any window from core ID 1, or from an undefined ID 5 to 7, sees st_ready high in the same cycle and is dropped. err_pulse is high for exactly the cycle after it.
- R6: Each queue holds 32 words. While a queue is full and its consumer is not popping, a store routed to it sees st_ready low and its word is not stored.
- R7: On a full queue, a push and a pop in the same cycle are both accepted, and occupancy stays at 32.
- R8: pop_valid of a thread is high whenever its occupancy is non-zero, and pop_data shows the oldest word. Words leave in the order they were accepted. occupancy, 6 bits per thread with thread t at bits [6t+5:6t], counts the stored words.
- R9: A store outside all three windows is accepted at once and dropped, with no error, from any core.
- R10: After synchronous reset, all queues are empty, pop_valid and occupancy are zero, hang_status and err_pulse are zero, and st_ready is high for a legal store to an empty queue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store request present |
| st_core | input | 3 | Issuing core ID |
| st_addr | input | 32 | Store byte address |
| st_data | input | 32 | Instruction word |
| st_ready | output | 1 | Store accepted this cycle |
| pop_ready | input | 3 | Consumer ready, one bit per thread |
| pop_valid | output | 3 | Queue non-empty, one bit per thread |
| pop_data | output | 96 | Head word per thread, thread t at [32t+31:32t] |
| occupancy | output | 18 | Stored word count per thread, 6 bits each |
| hang_status | output | 5 | Sticky hang flag, indexed by core ID |
| err_pulse | output | 1 | One-cycle flag after a forbidden store |

## Verification
On every cycle, the assertions check the following: queue counts never pass the depth, no word goes into a full queue that is not popping, hang flags stay set, a hang blocks the store port, a forbidden store is followed by an error pulse, and pop_valid tracks occupancy. The routing table itself can only be shown by the bench scenarios. These cover which core and which window reach which thread, how offsets inside a window decode, the order in which words leave each queue, and the simultaneous push and pop on a full queue. The scenarios also show that dropped stores leave the queues untouched.

// File: rtl/ipush_pkg.sv
package ipush_pkg;
    localparam int NUM_THREADS = 3;
    localparam int NUM_CORES   = 5;
    localparam int FIFO_DEPTH  = 32;
    localparam int DATA_W      = 32;
    localparam int ADDR_W      = 32;
    localparam int CORE_W      = 3;
    localparam int WIN_SHIFT   = 16;
    localparam int TID_W       = $clog2(NUM_THREADS);
    localparam int OCC_W       = $clog2(FIFO_DEPTH + 1);
    localparam int WIN_IDX_W   = ADDR_W - WIN_SHIFT;

    localparam logic [ADDR_W-1:0] WIN_BASE  = 32'hFFE4_0000;
    localparam logic [CORE_W-1:0] CORE_CTRL = 3'd0;
    localparam logic [CORE_W-1:0] CORE_CMP0 = 3'd2;

    typedef enum logic [1:0] {
        ST_PUSH    = 2'd0,
        ST_HANG    = 2'd1,
        ST_ILLEGAL = 2'd2,
        ST_MISS    = 2'd3
    } st_kind_e;

    typedef struct packed {
        st_kind_e         kind;
        logic [TID_W-1:0] thread;
    } route_t;

    function automatic route_t route_store(input logic [CORE_W-1:0] core,
                                           input logic [ADDR_W-1:0] addr);
        route_t r;
        logic [ADDR_W-1:0]    offs;
        logic [WIN_IDX_W-1:0] win;
        logic                 in_win;
        offs   = addr - WIN_BASE;
        win    = offs[ADDR_W-1:WIN_SHIFT];
        in_win = (addr >= WIN_BASE) && (win < WIN_IDX_W'(NUM_THREADS));
        r.thread = '0;
        if (!in_win) begin
            r.kind = ST_MISS;
        end else if (core == CORE_CTRL) begin
            r.kind   = ST_PUSH;
            r.thread = win[TID_W-1:0];
        end else if (core >= CORE_CMP0 &&
                     core < CORE_CMP0 + CORE_W'(NUM_THREADS)) begin
            if (win == '0) begin
                r.kind   = ST_PUSH;
                r.thread = TID_W'(core - CORE_CMP0);
            end else begin
                r.kind = ST_HANG;
            end
        end else begin
            r.kind = ST_ILLEGAL;
        end
        return r;
    endfunction
endpackage

// File: rtl/ipush_decode.sv
module ipush_decode
    import ipush_pkg::*;
(
    input  logic                   st_valid,
    input  logic [CORE_W-1:0]      st_core,
    input  logic [ADDR_W-1:0]      st_addr,
    output route_t                 route,
    output logic [NUM_THREADS-1:0] push_req
);
    always_comb begin
        route = route_store(st_core, st_addr);
        for (int t = 0; t < NUM_THREADS; t++) begin
            push_req[t] = st_valid && (route.kind == ST_PUSH) &&
                          (route.thread == TID_W'(t));
        end
    end
endmodule

// File: rtl/ipush_fifo.sv
module ipush_fifo
    import ipush_pkg::*;
#(
    parameter int DEPTH = FIFO_DEPTH,
    parameter int DW    = DATA_W
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         push_en,
    input  logic [DW-1:0]                push_data,
    input  logic                         pop_ready,
    output logic                         pop_valid,
    output logic [DW-1:0]                pop_data,
    output logic                         can_push,
    output logic [$clog2(DEPTH+1)-1:0]   occ
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [DW-1:0]    mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             full, pop_fire;

    assign full      = (count == CNT_W'(DEPTH));
    assign pop_valid = (count != '0);
    assign pop_fire  = pop_valid && pop_ready;
    assign can_push  = !full || pop_fire;
    assign pop_data  = mem[rd_ptr];
    assign occ       = count;

    always_ff @(posedge clk) begin
        if (push_en) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_en)
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop_fire)
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({push_en, pop_fire})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R6: occupancy never exceeds the depth
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));
    // R6: a push into a full queue only when the same cycle pops
    a_r6_full_push_needs_pop: assert property (@(posedge clk) disable iff (rst)
        (push_en && count == CNT_W'(DEPTH)) |-> pop_ready);
    // R7: simultaneous push and pop on a full queue keeps it full
    a_r7_full_swap: assert property (@(posedge clk) disable iff (rst)
        (push_en && pop_ready && count == CNT_W'(DEPTH)) |=> count == CNT_W'(DEPTH));
endmodule

// File: rtl/ipush_guard.sv
module ipush_guard
    import ipush_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 st_valid,
    input  logic [CORE_W-1:0]    st_core,
    input  route_t               route,
    output logic [NUM_CORES-1:0] hang_status,
    output logic                 blocked,
    output logic                 err_pulse
);
    logic [NUM_CORES-1:0] hang_q;
    logic                 err_q;
    logic                 live;

    assign live        = st_valid && !blocked;
    assign blocked     = |hang_q;
    assign hang_status = hang_q;
    assign err_pulse   = err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hang_q <= '0;
            err_q  <= 1'b0;
        end else begin
            err_q <= live && (route.kind == ST_ILLEGAL);
            for (int c = 0; c < NUM_CORES; c++) begin
                if (live && route.kind == ST_HANG && st_core == CORE_W'(c))
                    hang_q[c] <= 1'b1;
            end
        end
    end

    generate
        for (genvar c = 0; c < NUM_CORES; c++) begin : g_sticky
            // R4: a hang flag, once set, stays set
            a_r4_hang_sticky: assert property (@(posedge clk) disable iff (rst)
                hang_q[c] |=> hang_q[c]);
        end
    endgenerate
endmodule

// File: rtl/instr_push_hub.sv
module instr_push_hub
    import ipush_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             st_valid,
    input  logic [CORE_W-1:0]                st_core,
    input  logic [ADDR_W-1:0]                st_addr,
    input  logic [DATA_W-1:0]                st_data,
    output logic                             st_ready,
    input  logic [NUM_THREADS-1:0]           pop_ready,
    output logic [NUM_THREADS-1:0]           pop_valid,
    output logic [NUM_THREADS*DATA_W-1:0]    pop_data,
    output logic [NUM_THREADS*OCC_W-1:0]     occupancy,
    output logic [NUM_CORES-1:0]             hang_status,
    output logic                             err_pulse
);
    route_t                 route;
    logic [NUM_THREADS-1:0] push_req, push_en, can_push;
    logic                   blocked;

    ipush_decode u_decode (
        .st_valid (st_valid),
        .st_core  (st_core),
        .st_addr  (st_addr),
        .route    (route),
        .push_req (push_req)
    );

    ipush_guard u_guard (
        .clk         (clk),
        .rst         (rst),
        .st_valid    (st_valid),
        .st_core     (st_core),
        .route       (route),
        .hang_status (hang_status),
        .blocked     (blocked),
        .err_pulse   (err_pulse)
    );

    always_comb begin
        if (blocked) begin
            st_ready = 1'b0;
        end else begin
            case (route.kind)
                ST_PUSH: st_ready = can_push[route.thread];
                ST_HANG: st_ready = 1'b0;
                default: st_ready = 1'b1;
            endcase
        end
    end

    assign push_en = push_req & {NUM_THREADS{st_ready}};

    generate
        for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thread
            ipush_fifo #(.DEPTH(FIFO_DEPTH), .DW(DATA_W)) u_fifo (
                .clk       (clk),
                .rst       (rst),
                .push_en   (push_en[t]),
                .push_data (st_data),
                .pop_ready (pop_ready[t]),
                .pop_valid (pop_valid[t]),
                .pop_data  (pop_data[t*DATA_W +: DATA_W]),
                .can_push  (can_push[t]),
                .occ       (occupancy[t*OCC_W +: OCC_W])
            );

            // R8: pop_valid follows a non-zero occupancy
            a_r8_valid_tracks_occ: assert property (@(posedge clk) disable iff (rst)
                pop_valid[t] == (occupancy[t*OCC_W +: OCC_W] != '0));
            // R6: a store routed to a full, idle queue is stalled
            a_r6_stall_when_full: assert property (@(posedge clk) disable iff (rst)
                (push_req[t] && occupancy[t*OCC_W +: OCC_W] == OCC_W'(FIFO_DEPTH)
                 && !pop_ready[t]) |-> !st_ready);
        end
    endgenerate

    // R4: any hang flag blocks the store port
    a_r4_hang_blocks: assert property (@(posedge clk) disable iff (rst)
        (|hang_status) |-> !st_ready);
    // R5: an accepted forbidden store raises the error flag next cycle
    a_r5_err_follows: assert property (@(posedge clk) disable iff (rst)
        (st_valid && st_ready && route.kind == ST_ILLEGAL) |=> err_pulse);
    // R4: a hanging store never completes
    a_r4_hang_never_ready: assert property (@(posedge clk) disable iff (rst)
        (st_valid && route.kind == ST_HANG) |-> !st_ready);
endmodule

// File: tb/sim_instr_push_hub.sv
`timescale 1ns/100ps
module sim_instr_push_hub;
    logic        clk = 1'b0;
    logic        rst;
    logic        st_valid;
    logic [2:0]  st_core;
    logic [31:0] st_addr, st_data;
    logic        st_ready;
    logic [2:0]  pop_ready, pop_valid;
    logic [95:0] pop_data;
    logic [17:0] occupancy;
    logic [4:0]  hang_status;
    logic        err_pulse;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [31:0] q0[$], q1[$], q2[$];

    always #2.5 clk = ~clk;

    instr_push_hub u0 (
        .clk(clk), .rst(rst), .st_valid(st_valid), .st_core(st_core),
        .st_addr(st_addr), .st_data(st_data), .st_ready(st_ready),
        .pop_ready(pop_ready), .pop_valid(pop_valid), .pop_data(pop_data),
        .occupancy(occupancy), .hang_status(hang_status), .err_pulse(err_pulse)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [5:0] occ_of(input int t);
        return occupancy[t*6 +: 6];
    endfunction

    task automatic push_exp(input int t, input logic [31:0] d);
        case (t)
            0: q0.push_back(d);
            1: q1.push_back(d);
            default: q2.push_back(d);
        endcase
    endtask

    // driver: holds the store until accepted, records expected words
    task automatic do_store(input logic [2:0] c, input logic [31:0] a,
                            input logic [31:0] d, input int exp_t,
                            output int waits);
        bit acc = 0;
        waits = 0;
        while (!acc && waits < 100) begin
            @(negedge clk);
            st_valid = 1'b1; st_core = c; st_addr = a; st_data = d;
            #1;
            if (st_ready) begin
                acc = 1;
                if (exp_t >= 0) push_exp(exp_t, d);
            end else begin
                waits++;
            end
            @(posedge clk);
            #0.5 st_valid = 1'b0;
        end
    endtask

    // probe: present a store for part of one cycle, report ready, withdraw
    task automatic probe(input logic [2:0] c, input logic [31:0] a, output bit r);
        @(negedge clk);
        st_valid = 1'b1; st_core = c; st_addr = a; st_data = 32'hDEAD_0000;
        #1 r = st_ready;
        st_valid = 1'b0;
    endtask

    // monitor: compares every popped word against the scoreboard
    always begin
        @(negedge clk);
        #2;
        if (!rst) begin
            for (int t = 0; t < 3; t++) begin
                if (pop_valid[t] && pop_ready[t]) begin
                    logic [31:0] e;
                    int sz;
                    sz = (t == 0) ? q0.size() : (t == 1) ? q1.size() : q2.size();
                    if (sz == 0) begin
                        chk(0, "R8 unexpected pop", pop_data[t*32 +: 32], 32'h0);
                    end else begin
                        e = (t == 0) ? q0.pop_front() :
                            (t == 1) ? q1.pop_front() : q2.pop_front();
                        chk(pop_data[t*32 +: 32] == e, "R8 order/R2/R3 routing",
                            pop_data[t*32 +: 32], e);
                    end
                end
            end
        end
    end

    task automatic finish_up;
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        finish_up();
    end

    initial begin
        int w;
        bit r;
        rst = 1'b1; st_valid = 1'b0; st_core = '0; st_addr = '0; st_data = '0;
        pop_ready = 3'b000;
        repeat (3) @(posedge clk);
        #0.5 rst = 1'b0;

        // R10 reset state
        @(negedge clk);
        chk(occupancy == '0 && pop_valid == '0, "R10 queues empty", {14'h0, occupancy}, 32'h0);
        chk(hang_status == '0 && !err_pulse, "R10 flags clear", {27'h0, hang_status}, 32'h0);
        probe(3'd0, 32'hFFE4_0000, r);
        chk(r, "R10 ready after reset", {31'h0, r}, 32'h1);

        // R1/R2 control core, windows and offsets
        do_store(3'd0, 32'hFFE4_0000, 32'hA000_0001, 0, w);
        do_store(3'd0, 32'hFFE5_1234, 32'hA100_0002, 1, w);
        do_store(3'd0, 32'hFFE6_FFFC, 32'hA200_0003, 2, w);
        do_store(3'd0, 32'hFFE6_0010, 32'hA200_0004, 2, w);
        do_store(3'd0, 32'hFFE4_FFF0, 32'hA000_0005, 0, w);
        @(negedge clk);
        chk(occ_of(0) == 6'd2, "R1 R2 thread0 count", {26'h0, occ_of(0)}, 32'd2);
        chk(occ_of(1) == 6'd1, "R1 R2 thread1 count", {26'h0, occ_of(1)}, 32'd1);
        chk(occ_of(2) == 6'd2, "R1 R2 thread2 count", {26'h0, occ_of(2)}, 32'd2);
        pop_ready = 3'b111;
        repeat (6) @(negedge clk);
        chk(occupancy == '0, "R8 drained", {14'h0, occupancy}, 32'h0);
        pop_ready = 3'b000;

        // R3 compute cores remapped through window 0
        do_store(3'd2, 32'hFFE4_0008, 32'hB000_0000, 0, w);
        do_store(3'd3, 32'hFFE4_0008, 32'hB100_0001, 1, w);
        do_store(3'd4, 32'hFFE4_0100, 32'hB200_0002, 2, w);
        @(negedge clk);
        chk(occ_of(0) == 1 && occ_of(1) == 1 && occ_of(2) == 1, "R3 remap counts",
            {14'h0, occupancy}, {14'h0, 18'b000001_000001_000001});
        pop_ready = 3'b111;
        repeat (4) @(negedge clk);
        pop_ready = 3'b000;

        // R5 forbidden core
        do_store(3'd1, 32'hFFE5_0000, 32'hC0C0_C0C0, -1, w);
        chk(w == 0, "R5 immediate ack", w, 32'h0);
        @(negedge clk);
        chk(err_pulse == 1'b1, "R5 err pulse", {31'h0, err_pulse}, 32'h1);
        @(negedge clk);
        chk(err_pulse == 1'b0, "R5 err one cycle", {31'h0, err_pulse}, 32'h0);
        do_store(3'd6, 32'hFFE4_0000, 32'hC1C1_C1C1, -1, w);
        @(negedge clk);
        chk(err_pulse == 1'b1, "R5 undefined id err", {31'h0, err_pulse}, 32'h1);
        chk(occupancy == '0, "R5 word dropped", {14'h0, occupancy}, 32'h0);

        // R9 outside the windows
        do_store(3'd0, 32'hFFE7_0000, 32'hD000_0000, -1, w);
        chk(w == 0, "R9 immediate ack", w, 32'h0);
        do_store(3'd1, 32'hFFE3_FFFC, 32'hD000_0001, -1, w);
        @(negedge clk);
        chk(!err_pulse && occupancy == '0, "R9 no error no push",
            {13'h0, err_pulse, occupancy}, 32'h0);

        // R6 fill thread 0
        for (int i = 0; i < 32; i++)
            do_store(3'd0, 32'hFFE4_0000, 32'hE000_0000 + i, 0, w);
        @(negedge clk);
        chk(occ_of(0) == 6'd32, "R6 full count", {26'h0, occ_of(0)}, 32'd32);
        probe(3'd2, 32'hFFE4_0000, r);
        chk(!r, "R6 stall when full", {31'h0, r}, 32'h0);
        @(negedge clk);
        chk(occ_of(0) == 6'd32, "R6 word kept out", {26'h0, occ_of(0)}, 32'd32);

        // R7 push and pop together on a full queue
        @(negedge clk);
        pop_ready = 3'b001;
        st_valid = 1'b1; st_core = 3'd0; st_addr = 32'hFFE4_0004; st_data = 32'hE000_0100;
        #1;
        chk(st_ready, "R7 push accepted while popping", {31'h0, st_ready}, 32'h1);
        if (st_ready) push_exp(0, 32'hE000_0100);
        @(posedge clk);
        #0.5 st_valid = 1'b0; pop_ready = 3'b000;
        @(negedge clk);
        chk(occ_of(0) == 6'd32, "R7 stays full", {26'h0, occ_of(0)}, 32'd32);
        pop_ready = 3'b111;
        repeat (36) @(negedge clk);
        chk(occupancy == '0 && q0.size() == 0, "R8 all words delivered",
            {14'h0, occupancy}, 32'h0);
        pop_ready = 3'b000;

        // R4 hang from compute core 1 (ID 3) to window 2
        probe(3'd3, 32'hFFE6_0000, r);
        chk(!r, "R4 hang not ready", {31'h0, r}, 32'h0);
        @(negedge clk);
        st_valid = 1'b1; st_core = 3'd3; st_addr = 32'hFFE6_0000;
        @(posedge clk);
        #0.5 st_valid = 1'b0;
        @(negedge clk);
        chk(hang_status == 5'b01000, "R4 hang flag", {27'h0, hang_status}, 32'h8);
        repeat (3) @(negedge clk);
        probe(3'd0, 32'hFFE4_0000, r);
        chk(!r, "R4 port stays blocked", {31'h0, r}, 32'h0);
        chk(hang_status == 5'b01000 && occupancy == '0, "R4 sticky and nothing pushed",
            {9'h0, hang_status, occupancy}, {9'h0, 5'b01000, 18'h0});

        finish_up();
    end
endmodule